// File: doc/BRIEF.md
# AXI-Lite Page Router with Default Responder

This block sits between one AXI-Lite master and five register targets that each own a single 4 KB page of the address space. Three of the pages hold the register files of the clock-group PLLs, one holds the PLL that feeds the memory interface, and one holds a small local register file. The page map is neither contiguous nor in ascending order. The router compares the address bits above the page offset and steers each transaction to exactly one target. A transaction whose address misses every page is finished by the router itself. An unmapped write is dropped. An unmapped read returns a fixed signature word.

The write path and the read path are separate state machines, and each has at most one transaction in flight. The master side follows the AXI valid/ready rules. The router accepts a new address on a channel only while that channel is idle. It holds `s_awready` or `s_arready` low from the address handshake until the response handshake on that channel. A master that holds `s_bready` or `s_rready` low stalls only its own channel. The response stays on the port, unchanged, until the master takes it. On the target side, an address valid goes to the selected target only, and a target's ready or response valid counts only while that target is selected.

The router registers the address and the selected target at the address handshake. A later address therefore cannot redirect a transaction that is still in flight. Write data can arrive before or after its address. The router does not accept the data beat until it knows the target, and it then passes the beat straight to that target.

Top module: `axil_region_router`

## Requirements
- R1: The page index is address bits [31:12]. The targets are indexed as follows: page 0x00050 is target 0 (group B), 0x00051 is target 1 (group C), 0x00052 is target 2 (group A), 0x00054 is target 3 (memory PLL) and 0x00058 is target 4 (local registers). Each write or read to a mapped page completes at that target only, and no other target takes part in it.
- R2: The router ignores the offset bits [11:0] when it decodes, and it compares all of bits [31:12]. Any offset in a page, including 0xFFC, reaches that page's target. The target sees the full 32-bit address unchanged. An address with differing upper bits, or in a gap page, is unmapped.
- R3: An unmapped write accepts its address and data beats and answers with response 2'b00 (OKAY). No target sees any valid on any channel.
- R4: An unmapped read returns data 0xDEADDEC0 with response 2'b00, and no target sees any valid.
- R5: On each of the target address-write, write-data and address-read channels, at most one target valid is high in any cycle.
- R6: The address beat and the data beat of a write may come in either order, with any gap between them. The data always goes to the target selected by that write's address.
- R7: Each channel holds one transaction at a time. `s_awready` is low from the AW handshake until the B handshake, and `s_arready` is low from the AR handshake until the R handshake.
- R8: For a mapped access, the B and R response codes and the read data are those of the selected target, passed through unchanged.
- R9: Once `s_bvalid` or `s_rvalid` is high, it stays high with a stable payload until the matching ready is seen.
- R10: The read and write paths are independent. A read can complete while a write waits for its B handshake.
- R11: After reset, `s_awready` and `s_arready` are high, and no response valid or target valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W (32) | Master write address |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | DATA_W (32) | Master write data |
| s_wstrb | input | DATA_W/8 (4) | Master byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Master takes write response |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W (32) | Master read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Master takes read data |
| s_rdata | output | DATA_W (32) | Read data |
| s_rresp | output | 2 | Read response code |
| t_awvalid | output | N_TGT (5) | Per-target write address valid |
| t_awready | input | N_TGT (5) | Per-target write address ready |
| t_awaddr | output | ADDR_W (32) | Latched write address, shared by all targets |
| t_wvalid | output | N_TGT (5) | Per-target write data valid |
| t_wready | input | N_TGT (5) | Per-target write data ready |
| t_wdata | output | DATA_W (32) | Write data, shared by all targets |
| t_wstrb | output | DATA_W/8 (4) | Byte enables, shared by all targets |
| t_bvalid | input | N_TGT (5) | Per-target write response valid |
| t_bready | output | N_TGT (5) | Per-target write response ready |
| t_bresp | input | 2*N_TGT (10) | Per-target write response codes, target i at [2i+1:2i] |
| t_arvalid | output | N_TGT (5) | Per-target read address valid |
| t_arready | input | N_TGT (5) | Per-target read address ready |
| t_araddr | output | ADDR_W (32) | Latched read address, shared by all targets |
| t_rvalid | input | N_TGT (5) | Per-target read data valid |
| t_rready | output | N_TGT (5) | Per-target read data ready |
| t_rdata | input | DATA_W*N_TGT (160) | Per-target read data, target i at [32i+31:32i] |
| t_rresp | input | 2*N_TGT (10) | Per-target read response codes |

## Verification
The bench builds the router with its default parameters. That gives a 32-bit address and data path, five targets on the default page map, a 12-bit page offset and 0xDEADDEC0 as the miss word. With these values, the bench can reach the page edges at offset 0xFFC, the gap pages between mapped ones, and an address that differs only above bit 19. Its behavioural targets take the address beat and the data beat independently and return a tagged read word. Target 3 answers with an error code, so the bench can see responses pass through.

// File: rtl/rr_pkg.sv
package rr_pkg;

  localparam int unsigned RR_ADDR_W   = 32;
  localparam int unsigned RR_DATA_W   = 32;
  localparam int unsigned RR_N_TGT    = 5;
  localparam int unsigned RR_PAGE_LSB = 12;

  // Page bases, target 0 in the least significant slot.
  localparam logic [RR_N_TGT*RR_ADDR_W-1:0] RR_DEF_BASE = {
    32'h0005_8000,   // 4: local registers
    32'h0005_4000,   // 3: memory-interface PLL
    32'h0005_2000,   // 2: group A PLL
    32'h0005_1000,   // 1: group C PLL
    32'h0005_0000    // 0: group B PLL
  };

  localparam logic [31:0] RR_MISS_WORD = 32'hDEAD_DEC0;
  localparam logic [1:0]  RESP_OKAY    = 2'b00;

  typedef enum logic [1:0] {WS_IDLE, WS_XFER, WS_RESP} wr_state_e;
  typedef enum logic [1:0] {RS_IDLE, RS_ADDR, RS_DATA} rd_state_e;

endpackage

// File: rtl/rr_region_decode.sv
module rr_region_decode #(
  parameter int unsigned ADDR_W   = rr_pkg::RR_ADDR_W,
  parameter int unsigned N_TGT    = rr_pkg::RR_N_TGT,
  parameter int unsigned PAGE_LSB = rr_pkg::RR_PAGE_LSB,
  parameter logic [N_TGT*ADDR_W-1:0] TGT_BASE = rr_pkg::RR_DEF_BASE
) (
  input  logic [ADDR_W-PAGE_LSB-1:0] page,
  output logic [N_TGT-1:0]           hit,
  output logic                       miss
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

  for (genvar g = 0; g < N_TGT; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] BASE = TGT_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [PAGE_W-1:0] BASE_PAGE = BASE[ADDR_W-1:PAGE_LSB];
    assign hit[g] = (page == BASE_PAGE);
  end

  assign miss = ~|hit;
endmodule

// File: rtl/rr_wr_steer.sv
module rr_wr_steer #(
  parameter int unsigned ADDR_W = rr_pkg::RR_ADDR_W,
  parameter int unsigned N_TGT  = rr_pkg::RR_N_TGT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_TGT-1:0]     hit,
  input  logic                 miss,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  output logic [1:0]           s_bresp,
  output logic [N_TGT-1:0]     t_awvalid,
  input  logic [N_TGT-1:0]     t_awready,
  output logic [ADDR_W-1:0]    t_awaddr,
  output logic [N_TGT-1:0]     t_wvalid,
  input  logic [N_TGT-1:0]     t_wready,
  input  logic [N_TGT-1:0]     t_bvalid,
  output logic [N_TGT-1:0]     t_bready,
  input  logic [2*N_TGT-1:0]   t_bresp
);
  import rr_pkg::*;

  wr_state_e          state_q;
  logic [N_TGT-1:0]   sel_q;
  logic               miss_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               aw_pend_q, w_pend_q;
  logic               aw_take, w_take, aw_left, w_left;
  logic [1:0]         bresp_sel;

  assign s_awready = (state_q == WS_IDLE);
  assign t_awaddr  = addr_q;
  assign t_awvalid = (state_q == WS_XFER && aw_pend_q) ? sel_q : '0;
  assign s_wready  = (state_q == WS_XFER) && w_pend_q && (miss_q || |(t_wready & sel_q));
  assign t_wvalid  = (state_q == WS_XFER && w_pend_q && s_wvalid) ? sel_q : '0;
  assign t_bready  = (state_q == WS_RESP && s_bready) ? sel_q : '0;
  assign s_bvalid  = (state_q == WS_RESP) && (miss_q || |(t_bvalid & sel_q));

  assign aw_take = (state_q == WS_XFER) && aw_pend_q && |(t_awready & sel_q);
  assign w_take  = s_wvalid && s_wready;
  assign aw_left = aw_pend_q && !aw_take;
  assign w_left  = w_pend_q && !w_take;

  always_comb begin
    bresp_sel = '0;
    for (int i = 0; i < N_TGT; i++)
      if (sel_q[i]) bresp_sel = bresp_sel | t_bresp[2*i +: 2];
  end
  assign s_bresp = miss_q ? RESP_OKAY : bresp_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      sel_q     <= '0;
      miss_q    <= 1'b0;
      addr_q    <= '0;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
    end else begin
      case (state_q)
        WS_IDLE: if (s_awvalid) begin
          sel_q     <= hit;
          miss_q    <= miss;
          addr_q    <= s_awaddr;
          aw_pend_q <= !miss;
          w_pend_q  <= 1'b1;
          state_q   <= WS_XFER;
        end
        WS_XFER: begin
          aw_pend_q <= aw_left;
          w_pend_q  <= w_left;
          if (!aw_left && !w_left) state_q <= WS_RESP;
        end
        WS_RESP: if (s_bvalid && s_bready) begin
          sel_q   <= '0;
          state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_rd_steer.sv
module rr_rd_steer #(
  parameter int unsigned ADDR_W = rr_pkg::RR_ADDR_W,
  parameter int unsigned DATA_W = rr_pkg::RR_DATA_W,
  parameter int unsigned N_TGT  = rr_pkg::RR_N_TGT,
  parameter logic [DATA_W-1:0] MISS_WORD = DATA_W'(rr_pkg::RR_MISS_WORD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TGT-1:0]        hit,
  input  logic                    miss,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  input  logic [ADDR_W-1:0]       s_araddr,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  output logic [DATA_W-1:0]       s_rdata,
  output logic [1:0]              s_rresp,
  output logic [N_TGT-1:0]        t_arvalid,
  input  logic [N_TGT-1:0]        t_arready,
  output logic [ADDR_W-1:0]       t_araddr,
  input  logic [N_TGT-1:0]        t_rvalid,
  output logic [N_TGT-1:0]        t_rready,
  input  logic [DATA_W*N_TGT-1:0] t_rdata,
  input  logic [2*N_TGT-1:0]      t_rresp
);
  import rr_pkg::*;

  rd_state_e          state_q;
  logic [N_TGT-1:0]   sel_q;
  logic               miss_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  rdata_sel;
  logic [1:0]         rresp_sel;

  assign s_arready = (state_q == RS_IDLE);
  assign t_araddr  = addr_q;
  assign t_arvalid = (state_q == RS_ADDR) ? sel_q : '0;
  assign t_rready  = (state_q == RS_DATA && s_rready) ? sel_q : '0;
  assign s_rvalid  = (state_q == RS_DATA) && (miss_q || |(t_rvalid & sel_q));

  always_comb begin
    rdata_sel = '0;
    rresp_sel = '0;
    for (int i = 0; i < N_TGT; i++)
      if (sel_q[i]) begin
        rdata_sel = rdata_sel | t_rdata[DATA_W*i +: DATA_W];
        rresp_sel = rresp_sel | t_rresp[2*i +: 2];
      end
  end
  assign s_rdata = miss_q ? MISS_WORD : rdata_sel;
  assign s_rresp = miss_q ? RESP_OKAY : rresp_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      sel_q   <= '0;
      miss_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        RS_IDLE: if (s_arvalid) begin
          sel_q   <= hit;
          miss_q  <= miss;
          addr_q  <= s_araddr;
          state_q <= miss ? RS_DATA : RS_ADDR;
        end
        RS_ADDR: if (|(t_arready & sel_q)) state_q <= RS_DATA;
        RS_DATA: if (s_rvalid && s_rready) begin
          sel_q   <= '0;
          state_q <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axil_region_router.sv
module axil_region_router #(
  parameter int unsigned ADDR_W   = rr_pkg::RR_ADDR_W,
  parameter int unsigned DATA_W   = rr_pkg::RR_DATA_W,
  parameter int unsigned N_TGT    = rr_pkg::RR_N_TGT,
  parameter int unsigned PAGE_LSB = rr_pkg::RR_PAGE_LSB,
  parameter logic [N_TGT*ADDR_W-1:0] TGT_BASE = rr_pkg::RR_DEF_BASE,
  parameter logic [DATA_W-1:0] MISS_WORD = DATA_W'(rr_pkg::RR_MISS_WORD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_awvalid,
  output logic                    s_awready,
  input  logic [ADDR_W-1:0]       s_awaddr,
  input  logic                    s_wvalid,
  output logic                    s_wready,
  input  logic [DATA_W-1:0]       s_wdata,
  input  logic [DATA_W/8-1:0]     s_wstrb,
  output logic                    s_bvalid,
  input  logic                    s_bready,
  output logic [1:0]              s_bresp,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  input  logic [ADDR_W-1:0]       s_araddr,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  output logic [DATA_W-1:0]       s_rdata,
  output logic [1:0]              s_rresp,
  output logic [N_TGT-1:0]        t_awvalid,
  input  logic [N_TGT-1:0]        t_awready,
  output logic [ADDR_W-1:0]       t_awaddr,
  output logic [N_TGT-1:0]        t_wvalid,
  input  logic [N_TGT-1:0]        t_wready,
  output logic [DATA_W-1:0]       t_wdata,
  output logic [DATA_W/8-1:0]     t_wstrb,
  input  logic [N_TGT-1:0]        t_bvalid,
  output logic [N_TGT-1:0]        t_bready,
  input  logic [2*N_TGT-1:0]      t_bresp,
  output logic [N_TGT-1:0]        t_arvalid,
  input  logic [N_TGT-1:0]        t_arready,
  output logic [ADDR_W-1:0]       t_araddr,
  input  logic [N_TGT-1:0]        t_rvalid,
  output logic [N_TGT-1:0]        t_rready,
  input  logic [DATA_W*N_TGT-1:0] t_rdata,
  input  logic [2*N_TGT-1:0]      t_rresp
);
  logic [N_TGT-1:0] aw_hit, ar_hit;
  logic             aw_miss, ar_miss;

  // Write data and strobes fan out to every target; only the selected
  // target sees t_wvalid.
  assign t_wdata = s_wdata;
  assign t_wstrb = s_wstrb;

  rr_region_decode #(.ADDR_W(ADDR_W), .N_TGT(N_TGT), .PAGE_LSB(PAGE_LSB), .TGT_BASE(TGT_BASE))
    u_aw_dec (.page(s_awaddr[ADDR_W-1:PAGE_LSB]), .hit(aw_hit), .miss(aw_miss));

  rr_region_decode #(.ADDR_W(ADDR_W), .N_TGT(N_TGT), .PAGE_LSB(PAGE_LSB), .TGT_BASE(TGT_BASE))
    u_ar_dec (.page(s_araddr[ADDR_W-1:PAGE_LSB]), .hit(ar_hit), .miss(ar_miss));

  rr_wr_steer #(.ADDR_W(ADDR_W), .N_TGT(N_TGT)) u_wr (
    .clk(clk), .rst_n(rst_n), .hit(aw_hit), .miss(aw_miss),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .t_awvalid(t_awvalid), .t_awready(t_awready), .t_awaddr(t_awaddr),
    .t_wvalid(t_wvalid), .t_wready(t_wready),
    .t_bvalid(t_bvalid), .t_bready(t_bready), .t_bresp(t_bresp)
  );

  rr_rd_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_TGT(N_TGT), .MISS_WORD(MISS_WORD)) u_rd (
    .clk(clk), .rst_n(rst_n), .hit(ar_hit), .miss(ar_miss),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .t_arvalid(t_arvalid), .t_arready(t_arready), .t_araddr(t_araddr),
    .t_rvalid(t_rvalid), .t_rready(t_rready), .t_rdata(t_rdata), .t_rresp(t_rresp)
  );
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_TGT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic [N_TGT-1:0]  t_awvalid,
  input logic [N_TGT-1:0]  t_wvalid,
  input logic [N_TGT-1:0]  t_arvalid
);
  // R5: a single target per channel
  a_r5_aw_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(t_awvalid));
  a_r5_w_single:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(t_wvalid));
  a_r5_ar_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(t_arvalid));

  // R7: no second address while a transaction is open
  a_r7_aw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && s_awready) |=> !s_awready);
  a_r7_ar_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && s_arready) |=> !s_arready);

  // R9: responses hold until taken
  a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
  a_r9_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
endmodule

bind axil_region_router rr_checker #(.DATA_W(DATA_W), .N_TGT(N_TGT)) u_rr_checker (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .t_awvalid(t_awvalid), .t_wvalid(t_wvalid), .t_arvalid(t_arvalid)
);

// File: tb/test_axil_region_router.sv
module test_axil_region_router;
  localparam int N  = 5;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0]    s_wstrb = 4'hF;
  logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]    s_bresp, s_rresp;
  logic [DW-1:0] s_rdata;

  logic [N-1:0]    t_awvalid, t_awready, t_wvalid, t_wready, t_bvalid, t_bready;
  logic [N-1:0]    t_arvalid, t_arready, t_rvalid, t_rready;
  logic [AW-1:0]   t_awaddr, t_araddr;
  logic [DW-1:0]   t_wdata;
  logic [3:0]      t_wstrb;
  logic [2*N-1:0]  t_bresp, t_rresp;
  logic [DW*N-1:0] t_rdata;

  axil_region_router i_axil_region_router (.*);

  // ---------------- behavioural targets ----------------
  logic [N-1:0]  got_aw, got_w, bv, rv;
  logic [AW-1:0] aw_q [N];
  logic [DW-1:0] wd_q [N];
  logic [AW-1:0] last_addr [N];
  logic [DW-1:0] last_data [N];
  logic [DW-1:0] rd_q [N];
  int            wcnt [N];

  assign t_awready = ~got_aw;
  assign t_wready  = ~got_w;
  assign t_arready = ~rv;
  assign t_bvalid  = bv;
  assign t_rvalid  = rv;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      t_bresp[2*i +: 2] = (i == 3) ? 2'b10 : 2'b00;
      t_rresp[2*i +: 2] = (i == 3) ? 2'b10 : 2'b00;
      t_rdata[DW*i +: DW] = rd_q[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        got_aw[i] <= 0; got_w[i] <= 0; bv[i] <= 0; rv[i] <= 0;
        aw_q[i] <= '0; wd_q[i] <= '0; rd_q[i] <= '0;
        last_addr[i] <= '0; last_data[i] <= '0; wcnt[i] <= 0;
      end else begin
        if (t_awvalid[i] && t_awready[i]) begin got_aw[i] <= 1; aw_q[i] <= t_awaddr; end
        if (t_wvalid[i] && t_wready[i]) begin got_w[i] <= 1; wd_q[i] <= t_wdata; end
        if (got_aw[i] && got_w[i] && !bv[i]) begin
          bv[i] <= 1; wcnt[i] <= wcnt[i] + 1;
          last_addr[i] <= aw_q[i]; last_data[i] <= wd_q[i];
        end
        if (bv[i] && t_bready[i]) begin bv[i] <= 0; got_aw[i] <= 0; got_w[i] <= 0; end
        if (t_arvalid[i] && t_arready[i]) begin
          rv[i] <= 1; rd_q[i] <= {4'hA, 4'(i), t_araddr[23:0]};
        end
        if (rv[i] && t_rready[i]) rv[i] <= 0;
      end
    end
  end

  // ---------------- monitors ----------------
  int touch = 0, multi = 0;
  always @(posedge clk) if (rst_n && (|t_awvalid || |t_wvalid || |t_arvalid)) touch++;
  always @(negedge clk) if (rst_n && ($countones(t_awvalid) > 1 || $countones(t_wvalid) > 1 ||
                                       $countones(t_arvalid) > 1)) multi++;

  // ---------------- checking ----------------
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [31:0] a);
    case (a[31:12])
      20'h00050: return 0;
      20'h00051: return 1;
      20'h00052: return 2;
      20'h00054: return 3;
      20'h00058: return 4;
      default:   return -1;
    endcase
  endfunction

  function automatic int wsum();
    int s = 0;
    for (int i = 0; i < N; i++) s += wcnt[i];
    return s;
  endfunction

  task automatic drive_aw(input logic [31:0] a, input int dly);
    repeat (dly) @(negedge clk);
    s_awaddr = a; s_awvalid = 1;
    while (!s_awready) @(negedge clk);
    @(negedge clk); s_awvalid = 0;
  endtask

  task automatic drive_w(input logic [31:0] d, input int dly);
    repeat (dly) @(negedge clk);
    s_wdata = d; s_wvalid = 1;
    while (!s_wready) @(negedge clk);
    @(negedge clk); s_wvalid = 0;
  endtask

  task automatic take_b(output logic [1:0] resp);
    s_bready = 1;
    while (!s_bvalid) @(negedge clk);
    resp = s_bresp;
    @(negedge clk); s_bready = 0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic [1:0] resp);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 0; s_rready = 1;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata; resp = s_rresp;
    @(negedge clk); s_rready = 0;
  endtask

  // R11
  task automatic t_reset_state();
    chk(s_awready && s_arready, "R11 ready after reset", {30'd0, s_awready, s_arready}, 32'h3);
    chk(!s_bvalid && !s_rvalid, "R11 no response after reset", {30'd0, s_bvalid, s_rvalid}, 32'h0);
    chk(t_awvalid == 0 && t_wvalid == 0 && t_arvalid == 0, "R11 target valids idle",
        32'(t_awvalid | t_wvalid | t_arvalid), 32'h0);
  endtask

  // R1 R2 R3 R8 R6: one write, with chosen beat order
  task automatic t_write(input logic [31:0] a, input logic [31:0] d, input int aw_dly, input int w_dly);
    int idx = exp_idx(a);
    int old_sum = wsum();
    int old_touch = touch;
    int old_cnt = (idx >= 0) ? wcnt[idx] : 0;
    logic [1:0] resp;
    fork
      drive_aw(a, aw_dly);
      drive_w(d, w_dly);
    join
    take_b(resp);
    if (idx >= 0) begin
      chk(wcnt[idx] == old_cnt + 1, "R1 write reached its target", 32'(wcnt[idx]), 32'(old_cnt + 1));
      chk(wsum() == old_sum + 1, "R1 no other target written", 32'(wsum()), 32'(old_sum + 1));
      chk(last_addr[idx] == a, "R2 full address at target", last_addr[idx], a);
      chk(last_data[idx] == d, "R6 data at target of its address", last_data[idx], d);
      chk(resp == ((idx == 3) ? 2'b10 : 2'b00), "R8 bresp passthrough", 32'(resp),
          (idx == 3) ? 32'h2 : 32'h0);
    end else begin
      chk(touch == old_touch, "R3 unmapped write touched no target", 32'(touch), 32'(old_touch));
      chk(wsum() == old_sum, "R3 unmapped write discarded", 32'(wsum()), 32'(old_sum));
      chk(resp == 2'b00, "R3 unmapped write OKAY", 32'(resp), 32'h0);
    end
  endtask

  // R1 R2 R4 R8
  task automatic t_read(input logic [31:0] a);
    int idx = exp_idx(a);
    int old_touch = touch;
    logic [31:0] d;
    logic [1:0] resp;
    do_read(a, d, resp);
    if (idx >= 0) begin
      chk(d == {4'hA, 4'(idx), a[23:0]}, "R1 read data from its target", d, {4'hA, 4'(idx), a[23:0]});
      chk(resp == ((idx == 3) ? 2'b10 : 2'b00), "R8 rresp passthrough", 32'(resp),
          (idx == 3) ? 32'h2 : 32'h0);
    end else begin
      chk(d == 32'hDEADDEC0, "R4 unmapped read word", d, 32'hDEADDEC0);
      chk(resp == 2'b00 && touch == old_touch, "R4 unmapped read OKAY and untouched",
          {30'd0, resp}, 32'h0);
    end
  endtask

  // R7 R9: hold the write response and probe the address channel
  task automatic t_b_hold();
    logic [1:0] r0, resp;
    fork
      drive_aw(32'h0005_0010, 0);
      drive_w(32'h1111_2222, 0);
    join
    while (!s_bvalid) @(negedge clk);
    r0 = s_bresp;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(s_bvalid && s_bresp == r0, "R9 bvalid held while bready low", {31'd0, s_bvalid}, 32'h1);
      chk(!s_awready, "R7 no new AW while B pending", {31'd0, s_awready}, 32'h0);
    end
    take_b(resp);
    @(negedge clk);
    chk(s_awready, "R7 AW reopens after B", {31'd0, s_awready}, 32'h1);
  endtask

  // R7 R9: hold the read response
  task automatic t_r_hold();
    logic [31:0] d0;
    s_araddr = 32'h0005_8004; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d0 = s_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(s_rvalid && s_rdata == d0, "R9 rdata held while rready low", s_rdata, d0);
      chk(!s_arready, "R7 no new AR while R pending", {31'd0, s_arready}, 32'h0);
    end
    s_rready = 1;
    @(negedge clk); s_rready = 0;
    chk(d0 == 32'hA4_058004, "R1 held read data value", d0, 32'hA4_058004);
  endtask

  // R10: read completes while the write waits for its response
  task automatic t_concurrent();
    logic [31:0] d;
    logic [1:0] resp, bresp;
    fork
      drive_aw(32'h0005_4020, 0);
      drive_w(32'hCAFE_0001, 1);
    join
    while (!s_bvalid) @(negedge clk);
    do_read(32'h0005_2100, d, resp);
    chk(d == 32'hA2_052100, "R10 read during pending write", d, 32'hA2_052100);
    chk(s_bvalid, "R10 write response still pending", {31'd0, s_bvalid}, 32'h1);
    take_b(bresp);
    chk(bresp == 2'b10, "R10 write completed after read", 32'(bresp), 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_reset_state();

    // every page, varied offsets (R1, R2)
    t_write(32'h0005_0000, 32'h0000_00B0, 0, 0);
    t_write(32'h0005_1ABC, 32'h0000_00C0, 0, 0);
    t_write(32'h0005_2FFC, 32'h0000_00A0, 0, 0);
    t_write(32'h0005_4008, 32'h0000_0400, 0, 0);
    t_write(32'h0005_8FFC, 32'h0000_0800, 0, 0);
    // gaps and upper bits (R2, R3)
    t_write(32'h0005_3000, 32'hBAD0_0001, 0, 0);
    t_write(32'h0005_7FFC, 32'hBAD0_0002, 0, 0);
    t_write(32'h1005_8000, 32'hBAD0_0003, 0, 0);
    // beat order (R6)
    t_write(32'h0005_1010, 32'h5151_0001, 4, 0);
    t_write(32'h0005_4044, 32'h5454_0002, 0, 4);
    t_write(32'h0005_9000, 32'hBAD0_0004, 0, 3);

    t_read(32'h0005_0FFC);
    t_read(32'h0005_1000);
    t_read(32'h0005_2abc);
    t_read(32'h0005_4010);
    t_read(32'h0005_8000);
    t_read(32'h0005_5000);
    t_read(32'h8005_2000);

    t_b_hold();
    t_r_hold();
    t_concurrent();

    chk(multi == 0, "R5 one target valid per channel", 32'(multi), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule